// File: doc/BRIEF.md
# Top-N Zero-Crossing Peak Store

This block sits after a peak-emphasis filter in a streaming lane-marking pipeline. It receives one signed filtered sample per cycle when `in_valid` is high, together with that sample's column address. It looks for falling sign changes and measures how wide each one is. It keeps a small table of the strongest locations, sorted by strength, for the image region being streamed.

A crossing begins at the last strictly positive sample and ends at the first strictly negative sample after it. Zero-valued samples between the two only lengthen the crossing. The strength of a crossing is the number of columns between those two samples. The table holds the `N_SLOTS` strongest crossings seen in the current region. A new crossing displaces the weakest entry only when it is strictly stronger than that entry.

The upstream logic pulses `region_done` to close a region. The block then streams the whole table out in descending strength, one slot per cycle. Each slot carries an entry-valid flag, and the final slot carries a last flag. Both the table and the crossing tracker then start empty for the next region.

Top module: `peak_rank_store`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low. The first region then reports every slot as empty unless a crossing was found in it.
- R2: A crossing fires when a strictly negative sample arrives and the most recent nonzero sample was strictly positive. The reported column is the column of that positive sample. The reported magnitude is the negative sample's column minus that column.
- R3: Samples equal to zero leave the tracked positive column unchanged, so they widen the measured span. They never create a crossing on their own.
- R4: A change from negative to positive, or a negative sample with no positive sample before it in the region, produces no entry.
- R5: When a region yields more than `N_SLOTS` crossings, only the `N_SLOTS` largest magnitudes are kept. They are emitted in descending magnitude, starting with slot 0.
- R6: Among equal magnitudes, the crossing that arrived first is emitted first. When the table is full, a new crossing whose magnitude equals the weakest stored magnitude is discarded.
- R7: A `region_done` sampled on a clock edge makes `out_valid` high for exactly `N_SLOTS` consecutive cycles, starting the cycle after that edge. `out_last` is high only on the final cycle of the burst. A sample accepted on the same edge as `region_done` belongs to the region being closed.
- R8: `region_done` empties the table and also clears the positive-sample tracking. A region that starts with negative samples therefore reports no crossing for them.
- R9: An empty slot is emitted with `out_ok` low and with `out_col` and `out_mag` both zero. Every valid entry has a nonzero magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_col | input | COL_W | Column address of the sample; must increase within a region |
| in_sample | input | SAMP_W | Signed filtered sample |
| region_done | input | 1 | Closes the current region; starts the emission burst |
| out_valid | output | 1 | Table slot present on the outputs |
| out_ok | output | 1 | The present slot holds a crossing |
| out_col | output | COL_W | Column of the stored crossing |
| out_mag | output | COL_W | Span (strength) of the stored crossing |
| out_last | output | 1 | Final slot of the burst |

## Verification
Internal faults show up only at the ports, in the burst that follows the next `region_done`, within `N_SLOTS` + 1 cycles of that edge. The possible faults are a stuck sign tracker, a wrong anchor column, an off-by-one in the sorted shift, or a table that does not clear. Any of them appears as a wrong column, a wrong magnitude, a wrong order, a missing or extra entry, or a stale entry in a later region. The directed regions are built so that each of these faults changes at least one emitted slot. The gaps are chosen to separate magnitude from column. Ties fill the last slot, regions end while the tracker is armed, and runs of zeros widen spans.

// File: rtl/zcps_pkg.sv
package zcps_pkg;
  // Sign tracker state: ARMED means the latest nonzero sample was positive.
  typedef enum logic {
    TRK_IDLE  = 1'b0,
    TRK_ARMED = 1'b1
  } trk_state_e;
endpackage

// File: rtl/zcps_xdet.sv
module zcps_xdet
  import zcps_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int SAMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [COL_W-1:0]         in_col,
  input  logic signed [SAMP_W-1:0] in_sample,
  input  logic                     region_done,
  output logic                     hit,
  output logic [COL_W-1:0]         hit_col,
  output logic [COL_W-1:0]         hit_mag
);

  trk_state_e       state_q, state_d;
  logic [COL_W-1:0] anchor_q, anchor_d;
  logic             is_pos, is_neg, upd_en;

  assign is_pos = in_valid && (in_sample > 0);
  assign is_neg = in_valid && (in_sample < 0);

  // Crossing decision is combinational; the table registers it.
  assign hit     = is_neg && (state_q == TRK_ARMED);
  assign hit_col = anchor_q;
  assign hit_mag = in_col - anchor_q;

  always_comb begin
    state_d  = state_q;
    anchor_d = anchor_q;
    if (is_pos) begin
      state_d  = TRK_ARMED;
      anchor_d = in_col;
    end else if (is_neg) begin
      state_d  = TRK_IDLE;
    end
    if (region_done) begin
      state_d  = TRK_IDLE;
      anchor_d = '0;
    end
  end

  assign upd_en = in_valid || region_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TRK_IDLE;
      anchor_q <= '0;
    end else if (upd_en) begin
      state_q  <= state_d;
      anchor_q <= anchor_d;
    end
  end

endmodule

// File: rtl/zcps_rank.sv
module zcps_rank #(
  parameter int N_SLOTS = 7,
  parameter int COL_W   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins,
  input  logic [COL_W-1:0]              ins_col,
  input  logic [COL_W-1:0]              ins_mag,
  input  logic                          clear,
  output logic [N_SLOTS-1:0]            mrg_ok,
  output logic [N_SLOTS-1:0][COL_W-1:0] mrg_col,
  output logic [N_SLOTS-1:0][COL_W-1:0] mrg_mag
);

  logic [N_SLOTS-1:0]            ok_q, ok_d;
  logic [N_SLOTS-1:0][COL_W-1:0] col_q, col_d;
  logic [N_SLOTS-1:0][COL_W-1:0] mag_q, mag_d;
  logic [N_SLOTS-1:0]            beats;
  logic                          tbl_en;

  // beats is a thermometer (0..0 1..1) because the table stays sorted.
  // Strict compare: equal magnitudes stay behind the earlier arrival.
  genvar gi;
  generate
    for (gi = 0; gi < N_SLOTS; gi++) begin : g_slot
      assign beats[gi] = ins && (!ok_q[gi] || (ins_mag > mag_q[gi]));
      if (gi == 0) begin : g_head
        always_comb begin
          if (beats[gi]) begin
            mrg_ok[gi]  = 1'b1;
            mrg_col[gi] = ins_col;
            mrg_mag[gi] = ins_mag;
          end else begin
            mrg_ok[gi]  = ok_q[gi];
            mrg_col[gi] = col_q[gi];
            mrg_mag[gi] = mag_q[gi];
          end
        end
      end else begin : g_body
        always_comb begin
          if (beats[gi] && !beats[gi-1]) begin
            mrg_ok[gi]  = 1'b1;
            mrg_col[gi] = ins_col;
            mrg_mag[gi] = ins_mag;
          end else if (beats[gi]) begin
            mrg_ok[gi]  = ok_q[gi-1];
            mrg_col[gi] = col_q[gi-1];
            mrg_mag[gi] = mag_q[gi-1];
          end else begin
            mrg_ok[gi]  = ok_q[gi];
            mrg_col[gi] = col_q[gi];
            mrg_mag[gi] = mag_q[gi];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    if (clear) begin
      ok_d  = '0;
      col_d = '0;
      mag_d = '0;
    end else begin
      ok_d  = mrg_ok;
      col_d = mrg_col;
      mag_d = mrg_mag;
    end
  end

  assign tbl_en = ins || clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= '0;
      col_q <= '0;
      mag_q <= '0;
    end else if (tbl_en) begin
      ok_q  <= ok_d;
      col_q <= col_d;
      mag_q <= mag_d;
    end
  end

endmodule

// File: rtl/zcps_emit.sv
module zcps_emit #(
  parameter int N_SLOTS = 7,
  parameter int COL_W   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [N_SLOTS-1:0]            ld_ok,
  input  logic [N_SLOTS-1:0][COL_W-1:0] ld_col,
  input  logic [N_SLOTS-1:0][COL_W-1:0] ld_mag,
  output logic                          out_valid,
  output logic                          out_ok,
  output logic [COL_W-1:0]              out_col,
  output logic [COL_W-1:0]              out_mag,
  output logic                          out_last
);

  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_SLOTS - 1);

  logic [N_SLOTS-1:0]            snap_ok_q;
  logic [N_SLOTS-1:0][COL_W-1:0] snap_col_q;
  logic [N_SLOTS-1:0][COL_W-1:0] snap_mag_q;
  logic                          busy_q, busy_d;
  logic [IDX_W-1:0]              idx_q, idx_d;
  logic                          at_end;

  assign at_end = (idx_q == IDX_END);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (at_end) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_ok_q  <= '0;
      snap_col_q <= '0;
      snap_mag_q <= '0;
    end else if (load) begin
      snap_ok_q  <= ld_ok;
      snap_col_q <= ld_col;
      snap_mag_q <= ld_mag;
    end
  end

  always_comb begin
    out_valid = busy_q;
    out_last  = busy_q && at_end;
    if (busy_q) begin
      out_ok  = snap_ok_q[idx_q];
      out_col = snap_col_q[idx_q];
      out_mag = snap_mag_q[idx_q];
    end else begin
      out_ok  = 1'b0;
      out_col = '0;
      out_mag = '0;
    end
  end

endmodule

// File: rtl/peak_rank_store.sv
module peak_rank_store #(
  parameter int N_SLOTS = 7,
  parameter int COL_W   = 10,
  parameter int SAMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [COL_W-1:0]         in_col,
  input  logic signed [SAMP_W-1:0] in_sample,
  input  logic                     region_done,
  output logic                     out_valid,
  output logic                     out_ok,
  output logic [COL_W-1:0]         out_col,
  output logic [COL_W-1:0]         out_mag,
  output logic                     out_last
);

  logic                          hit;
  logic [COL_W-1:0]              hit_col, hit_mag;
  logic [N_SLOTS-1:0]            mrg_ok;
  logic [N_SLOTS-1:0][COL_W-1:0] mrg_col, mrg_mag;

  zcps_xdet #(.COL_W(COL_W), .SAMP_W(SAMP_W)) u_xdet (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_col     (in_col),
    .in_sample  (in_sample),
    .region_done(region_done),
    .hit        (hit),
    .hit_col    (hit_col),
    .hit_mag    (hit_mag)
  );

  zcps_rank #(.N_SLOTS(N_SLOTS), .COL_W(COL_W)) u_rank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ins    (hit),
    .ins_col(hit_col),
    .ins_mag(hit_mag),
    .clear  (region_done),
    .mrg_ok (mrg_ok),
    .mrg_col(mrg_col),
    .mrg_mag(mrg_mag)
  );

  // Snapshot takes the merged view so a same-edge crossing is included.
  zcps_emit #(.N_SLOTS(N_SLOTS), .COL_W(COL_W)) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (region_done),
    .ld_ok    (mrg_ok),
    .ld_col   (mrg_col),
    .ld_mag   (mrg_mag),
    .out_valid(out_valid),
    .out_ok   (out_ok),
    .out_col  (out_col),
    .out_mag  (out_mag),
    .out_last (out_last)
  );

endmodule

// File: rtl/peak_rank_store_chk.sv
module peak_rank_store_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             region_done,
  input logic             out_valid,
  input logic             out_ok,
  input logic [COL_W-1:0] out_col,
  input logic [COL_W-1:0] out_mag,
  input logic             out_last
);

  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    region_done |=> out_valid); // R7

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R7

  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !region_done) |=> !out_valid); // R7

  AST_DESCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !region_done && out_ok) |=>
      (!out_ok || (out_mag <= $past(out_mag)))); // R5

  AST_EMPTY_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !region_done && !out_ok) |=> !out_ok); // R9

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_col == '0 && out_mag == '0)); // R9

  AST_MAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok) |-> (out_mag != '0)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_ok && !out_last)); // R1

endmodule

bind peak_rank_store peak_rank_store_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .region_done(region_done),
  .out_valid  (out_valid),
  .out_ok     (out_ok),
  .out_col    (out_col),
  .out_mag    (out_mag),
  .out_last   (out_last)
);

// File: tb/peak_rank_store_bench.sv
`timescale 1ns/1ps
module peak_rank_store_bench;

  localparam int N_SLOTS = 7;
  localparam int COL_W   = 10;
  localparam int SAMP_W  = 16;
  localparam int MAXS    = 128;

  logic                     clk;
  logic                     rst_n;
  logic                     in_valid;
  logic [COL_W-1:0]         in_col;
  logic signed [SAMP_W-1:0] in_sample;
  logic                     region_done;
  logic                     out_valid, out_ok, out_last;
  logic [COL_W-1:0]         out_col, out_mag;

  int n_checks = 0;
  int n_fail   = 0;

  int s_col [MAXS];
  int s_val [MAXS];
  int s_n;
  int cur_col;

  peak_rank_store #(.N_SLOTS(N_SLOTS), .COL_W(COL_W), .SAMP_W(SAMP_W)) u_peak_rank_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
    .in_sample(in_sample), .region_done(region_done), .out_valid(out_valid),
    .out_ok(out_ok), .out_col(out_col), .out_mag(out_mag), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic new_region();
    s_n = 0;
    cur_col = 0;
  endtask

  task automatic push(input int v);
    s_col[s_n] = cur_col;
    s_val[s_n] = v;
    s_n++;
    cur_col++;
  endtask

  // One falling crossing whose span equals g (zeros fill the gap).
  task automatic push_span(input int g);
    push(9);
    for (int z = 1; z < g; z++) push(0);
    push(-9);
  endtask

  // Streams the region (region_done on the last sample) and checks the burst.
  task automatic run_region(input string req);
    int xc [MAXS];
    int xm [MAXS];
    bit used [MAXS];
    int m = 0;
    bit armed = 0;
    int anc = 0;
    for (int j = 0; j < s_n; j++) begin
      if (s_val[j] > 0) begin
        armed = 1; anc = s_col[j];
      end else if (s_val[j] < 0) begin
        if (armed) begin
          xc[m] = anc; xm[m] = s_col[j] - anc; used[m] = 0; m++;
        end
        armed = 0;
      end
    end
    for (int j = 0; j < s_n; j++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_col      = COL_W'(s_col[j]);
      in_sample   = SAMP_W'(s_val[j]);
      region_done = (j == s_n - 1);
    end
    for (int k = 0; k < N_SLOTS; k++) begin
      int best = -1;
      bit e_ok;
      int e_col, e_mag;
      @(negedge clk);
      in_valid = 1'b0; region_done = 1'b0; in_sample = '0; in_col = '0;
      for (int j = 0; j < m; j++)
        if (!used[j] && (best < 0 || xm[j] > xm[best])) best = j;
      if (best >= 0) used[best] = 1;
      e_ok  = (best >= 0);
      e_col = e_ok ? xc[best] : 0;
      e_mag = e_ok ? xm[best] : 0;
      check(out_valid && out_ok == e_ok && int'(out_col) == e_col &&
            int'(out_mag) == e_mag && out_last == (k == N_SLOTS - 1),
            $sformatf("%s slot %0d", req, k),
            $sformatf("v%0d ok%0d col%0d mag%0d last%0d", out_valid, out_ok, out_col, out_mag, out_last),
            $sformatf("v1 ok%0d col%0d mag%0d last%0d", e_ok, e_col, e_mag, (k == N_SLOTS - 1)));
    end
    @(negedge clk);
    check(!out_valid && !out_last, {req, " R7 burst end"},
          $sformatf("v%0d last%0d", out_valid, out_last), "v0 last0");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_col = '0; in_sample = '0; region_done = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last, "R1 reset", $sformatf("v%0d last%0d", out_valid, out_last), "v0 last0");
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 idle after release", $sformatf("v%0d", out_valid), "v0");
  endtask

  task automatic t_single();   // R2, R9: one crossing then empty slots
    new_region();
    push(5); push(7); push(-3); push(-2);
    run_region("R2 R9 single");
  endtask

  task automatic t_zeros();    // R3: zeros widen span
    new_region();
    push(4); push(0); push(0); push(0); push(-1); push(0); push(2); push(0); push(-6);
    run_region("R3 zero span");
  endtask

  task automatic t_rising();   // R4: rising changes and leading negatives ignored
    new_region();
    push(-5); push(0); push(6); push(3);
    run_region("R4 rising ignored");
  endtask

  task automatic t_overflow(); // R5: more than N crossings, keep strongest
    new_region();
    push_span(3); push_span(9); push_span(1); push_span(5); push_span(12);
    push_span(2); push_span(8); push_span(4); push_span(10); push_span(6);
    run_region("R5 top-N order");
  endtask

  task automatic t_ties();     // R6: ties keep earlier, equal-to-weakest dropped
    new_region();
    push_span(2); push_span(3); push_span(2); push_span(3); push_span(2);
    push_span(3); push_span(2); push_span(3); push_span(2); push_span(2);
    run_region("R6 ties");
  endtask

  task automatic t_clear();    // R8: region ends armed; next starts negative
    new_region();
    push(3); push(-1); push(4);
    run_region("R8 first region");
    new_region();
    push(-2); push(0); push(5); push(0); push(-5);
    run_region("R8 cleared region");
  endtask

  initial begin
    t_reset();
    t_single();
    t_zeros();
    t_rising();
    t_overflow();
    t_ties();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule